// File: doc/BRIEF.md
# Byte-Lane Register Access Adapter

This block joins an ISA I/O slave port to a bank of 16-bit internal registers. Software can reach those registers with full 16-bit bus cycles or with pairs of 8-bit cycles. The width is chosen from what the block has observed on the board.

The adapter begins in byte mode. It moves to word mode the first time it samples the board's 16-bit select line high after reset, and it stays in word mode until the next reset. In byte mode a read always returns data on the low data lane. When the byte address is odd, the upper half of the register is shifted down onto that lane. A byte write to an even address is parked in a holding register. The odd-address byte that follows it is moved to the upper half, joined with the parked byte and issued as a single internal 16-bit write. A word cycle is a word-mode cycle with the byte-high enable low and an even address. It moves both lanes directly and does not touch the holding register.

Every cycle stretches the ready line low for a fixed number of clocks. The data is driven only after ready is released, and it stays on the bus until the strobe goes away. One word address is reserved for reset. A read there emits a one-clock internal reset pulse, returns to byte mode and empties the holding register. A write there does nothing.

The control sequencer has four states:
- `ST_IDLE`: no cycle is in progress.
- `ST_WAIT`: the latency count is running.
- `ST_ACCESS`: the single clock in which the register strobe is issued.
- `ST_HOLD`: ready is released and the data drivers are on.

Its transitions are:
- start: `ST_IDLE`→`ST_WAIT`, taken when AEN is low and a strobe is active.
- count done: `ST_WAIT`→`ST_ACCESS`.
- access done: `ST_ACCESS`→`ST_HOLD`.
- strobe release: `ST_HOLD`→`ST_IDLE`.

Top module: `isa_lane_adapter`

## Requirements
- R1: After reset the ready line is high, both data-lane enables are low, the 16-bit select output is high (inactive), the register strobes and the soft reset are low, and the block is in byte mode.
- R2: The block enters word mode on the first clock in which `cs16_sense` is sampled high. It stays in word mode while `cs16_sense` is low again, and leaves it only on hardware reset or a reset-address read.
- R3: A cycle starts in a clock where `bus_aen` is 0 and `bus_ior_n` or `bus_iow_n` is 0. From the next clock, `bus_ready` stays low for exactly WAIT_CLKS+1 clocks and then stays high until both strobes are high.
- R4: A byte-cycle read drives only the low lane. Address bit 0 = 0 returns register bits 7:0 and bit 0 = 1 returns bits 15:8 on `bus_sd_lo`. `bus_sd_hi_oe` stays low. The register word index is address bits ADDR_W-1:1.
- R5: In word mode, a read with `bus_sbhe_n`=0 and address bit 0 = 0 drives both lanes: bits 7:0 on the low lane and bits 15:8 on the high lane.
- R6: A byte write to an even address issues no internal write. It only stores `bus_sd_in[7:0]` in the holding register.
- R7: A byte write to the odd address of the same word, as the very next cycle after the even write, issues exactly one internal write of {odd byte, held byte}. In both byte writes the byte is carried on `bus_sd_in[7:0]`.
- R8: An odd byte write issues no internal write when the previous cycle was not an even byte write to the same word.
- R9: A word write issues exactly one internal write of `bus_sd_in[15:0]`, bypassing the holding register.
- R10: A read of word index RST_IDX gives a one-clock `soft_rst` pulse, returns 0x00 on the low lane and returns the block to byte mode. A write there issues neither `soft_rst` nor an internal write.
- R11: `bus_cs16_n` is low during a cycle only in word mode, and never on a reset-address cycle.
- R12: With `bus_sbhe_n`=1, every cycle is a byte cycle even in word mode.
- R13: The data-lane enables are high only while ready is high inside a read cycle. They are low by the clock after both strobes go high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_aen | input | 1 | Address enable; a cycle is accepted only when 0 |
| bus_addr | input | ADDR_W | I/O byte address within the block |
| bus_ior_n | input | 1 | I/O read strobe, active low |
| bus_iow_n | input | 1 | I/O write strobe, active low |
| bus_sbhe_n | input | 1 | Byte-high enable, active low; 1 when unconnected |
| bus_sd_in | input | 16 | System data from the bus |
| cs16_sense | input | 1 | Sampled level of the board's 16-bit select line |
| bus_sd_lo | output | 8 | Low data lane out |
| bus_sd_hi | output | 8 | High data lane out |
| bus_sd_lo_oe | output | 1 | Low lane driver enable |
| bus_sd_hi_oe | output | 1 | High lane driver enable |
| bus_ready | output | 1 | Channel ready; low while the cycle is stretched |
| bus_cs16_n | output | 1 | 16-bit cycle indication, active low |
| reg_idx | output | ADDR_W-1 | Internal register word index |
| reg_rd | output | 1 | One-clock internal read strobe |
| reg_wr | output | 1 | One-clock internal write strobe |
| reg_wdata | output | 16 | Internal write data |
| reg_rdata | input | 16 | Internal read data, valid in the same clock as reg_rd |
| soft_rst | output | 1 | One-clock internal reset pulse |

## Verification
Reads of the same word at the even and the odd address, in byte mode, tell correct downward swapping apart from lane mix-ups. The same read then repeated in word mode with the byte-high enable low and then high separates the mode latch from the per-cycle width decision. Write pairs are tried in three orders: even then odd, a lone odd, and even with an unrelated read in between. Together with a word write, these show whether the holding register merges, bypasses and expires correctly. A reset-address read followed by a word-style read confirms that the mode latch is cleared, while a reset-address write confirms that it has no effect.

// File: rtl/lane_pkg.sv
package lane_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_ACCESS,
        ST_HOLD
    } lane_st_t;

    typedef struct packed {
        logic wr;
        logic word;
        logic odd;
        logic rst_hit;
    } cyc_attr_t;

endpackage

// File: rtl/lane_mode_track.sv
module lane_mode_track (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_clr,
    input  logic sense,
    output logic wide
);
    always_ff @(posedge clk) begin
        if (!rst_n)        wide <= 1'b0;
        else if (soft_clr) wide <= 1'b0;
        else if (sense)    wide <= 1'b1;
    end
endmodule

// File: rtl/lane_wait_timer.sv
module lane_wait_timer #(
    parameter int WAIT_CLKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CNT_W = (WAIT_CLKS < 2) ? 1 : $clog2(WAIT_CLKS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_CLKS - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (cnt != LAST) cnt <= cnt + 1'b1;
    end

    assign done = run && (cnt == LAST);
endmodule

// File: rtl/lane_byte_merge.sv
module lane_byte_merge #(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_clr,
    input  logic             acc_en,
    input  lane_pkg::cyc_attr_t attr,
    input  logic [IDX_W-1:0] idx,
    input  logic [15:0]      sd_in,
    output logic             wr_en,
    output logic [15:0]      wdata
);
    logic [7:0]       hold_byte;
    logic [IDX_W-1:0] hold_idx;
    logic             hold_vld;
    logic             pair_ok;
    logic             park;

    assign park    = attr.wr && !attr.word && !attr.odd && !attr.rst_hit;
    assign pair_ok = hold_vld && (hold_idx == idx);

    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) begin
            hold_vld  <= 1'b0;
            hold_byte <= '0;
            hold_idx  <= '0;
        end else if (acc_en) begin
            hold_vld <= park;
            if (park) begin
                hold_byte <= sd_in[7:0];
                hold_idx  <= idx;
            end
        end
    end

    always_comb begin
        wr_en = 1'b0;
        wdata = sd_in;
        if (acc_en && attr.wr && !attr.rst_hit) begin
            if (attr.word) begin
                wr_en = 1'b1;
            end else if (attr.odd && pair_ok) begin
                wr_en = 1'b1;
                wdata = {sd_in[7:0], hold_byte};
            end
        end
    end
endmodule

// File: rtl/lane_read_steer.sv
module lane_read_steer (
    input  logic        drive,
    input  logic        word,
    input  logic        odd,
    input  logic [15:0] rdata,
    output logic [7:0]  lo,
    output logic [7:0]  hi,
    output logic        lo_oe,
    output logic        hi_oe
);
    always_comb begin
        lo_oe = drive;
        hi_oe = drive && word;
        hi    = word ? rdata[15:8] : 8'h00;
        lo    = (!word && odd) ? rdata[15:8] : rdata[7:0];
    end
endmodule

// File: rtl/isa_lane_adapter.sv
module isa_lane_adapter #(
    parameter int ADDR_W    = 4,
    parameter int WAIT_CLKS = 3,
    parameter int RST_IDX   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_aen,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_ior_n,
    input  logic              bus_iow_n,
    input  logic              bus_sbhe_n,
    input  logic [15:0]       bus_sd_in,
    input  logic              cs16_sense,
    output logic [7:0]        bus_sd_lo,
    output logic [7:0]        bus_sd_hi,
    output logic              bus_sd_lo_oe,
    output logic              bus_sd_hi_oe,
    output logic              bus_ready,
    output logic              bus_cs16_n,
    output logic [ADDR_W-2:0] reg_idx,
    output logic              reg_rd,
    output logic              reg_wr,
    output logic [15:0]       reg_wdata,
    input  logic [15:0]       reg_rdata,
    output logic              soft_rst
);
    import lane_pkg::*;

    localparam int IDX_W = ADDR_W - 1;
    localparam logic [IDX_W-1:0] RST_W = IDX_W'(RST_IDX);

    lane_st_t         st, st_nx;
    cyc_attr_t        attr_q;
    logic [IDX_W-1:0] idx_q;
    logic [15:0]      rdata_q;
    logic             wide;
    logic             start;
    logic             strobe_on;
    logic             wait_done;

    assign strobe_on = !bus_ior_n || !bus_iow_n;
    assign start     = (st == ST_IDLE) && !bus_aen && strobe_on;

    lane_mode_track u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_clr (soft_rst),
        .sense    (cs16_sense),
        .wide     (wide)
    );

    lane_wait_timer #(.WAIT_CLKS(WAIT_CLKS)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (st == ST_WAIT),
        .done  (wait_done)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // next-state
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:   if (start)      st_nx = ST_WAIT;
            ST_WAIT:   if (wait_done)  st_nx = ST_ACCESS;
            ST_ACCESS:                 st_nx = ST_HOLD;
            ST_HOLD:   if (!strobe_on) st_nx = ST_IDLE;
            default:                   st_nx = ST_IDLE;
        endcase
    end

    // cycle attributes, latched at start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            attr_q <= '0;
            idx_q  <= '0;
        end else if (start) begin
            attr_q.wr      <= !bus_iow_n;
            attr_q.odd     <= bus_addr[0];
            attr_q.rst_hit <= (bus_addr[ADDR_W-1:1] == RST_W);
            attr_q.word    <= wide && !bus_sbhe_n && !bus_addr[0]
                              && (bus_addr[ADDR_W-1:1] != RST_W);
            idx_q          <= bus_addr[ADDR_W-1:1];
        end
    end

    // read data capture
    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else if (st == ST_ACCESS && !attr_q.wr)
            rdata_q <= attr_q.rst_hit ? 16'h0000 : reg_rdata;
    end

    lane_byte_merge #(.IDX_W(IDX_W)) u_merge (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_clr (soft_rst),
        .acc_en   (st == ST_ACCESS),
        .attr     (attr_q),
        .idx      (idx_q),
        .sd_in    (bus_sd_in),
        .wr_en    (reg_wr),
        .wdata    (reg_wdata)
    );

    lane_read_steer u_steer (
        .drive (st == ST_HOLD && !attr_q.wr),
        .word  (attr_q.word),
        .odd   (attr_q.odd),
        .rdata (rdata_q),
        .lo    (bus_sd_lo),
        .hi    (bus_sd_hi),
        .lo_oe (bus_sd_lo_oe),
        .hi_oe (bus_sd_hi_oe)
    );

    // outputs per state
    always_comb begin
        bus_ready  = 1'b1;
        bus_cs16_n = 1'b1;
        reg_rd     = 1'b0;
        soft_rst   = 1'b0;
        reg_idx    = idx_q;
        unique case (st)
            ST_IDLE: ;
            ST_WAIT: begin
                bus_ready  = 1'b0;
                bus_cs16_n = !(wide && !attr_q.rst_hit);
            end
            ST_ACCESS: begin
                bus_ready  = 1'b0;
                bus_cs16_n = !(wide && !attr_q.rst_hit);
                reg_rd     = !attr_q.wr && !attr_q.rst_hit;
                soft_rst   = !attr_q.wr && attr_q.rst_hit;
            end
            ST_HOLD: bus_cs16_n = !(wide && !attr_q.rst_hit);
            default: ;
        endcase
    end
endmodule

// File: rtl/isa_lane_adapter_chk.sv
module isa_lane_adapter_chk (
    input logic clk,
    input logic rst_n,
    input logic wide,
    input logic bus_ready,
    input logic bus_sd_lo_oe,
    input logic bus_sd_hi_oe,
    input logic bus_cs16_n,
    input logic reg_rd,
    input logic reg_wr,
    input logic soft_rst
);
    p_mode_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wide && !soft_rst) |=> wide);

    p_hi_lane_wide_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sd_hi_oe |-> (wide && bus_sd_lo_oe));

    p_wr_stretched_r7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> (!bus_ready && !reg_rd));

    p_soft_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!soft_rst && !wide));

    p_cs16_wide_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_cs16_n |-> wide);

    p_oe_ready_r13: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sd_lo_oe |-> bus_ready);

    p_rd_stretched_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |-> !bus_ready);
endmodule

bind isa_lane_adapter isa_lane_adapter_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wide         (wide),
    .bus_ready    (bus_ready),
    .bus_sd_lo_oe (bus_sd_lo_oe),
    .bus_sd_hi_oe (bus_sd_hi_oe),
    .bus_cs16_n   (bus_cs16_n),
    .reg_rd       (reg_rd),
    .reg_wr       (reg_wr),
    .soft_rst     (soft_rst)
);

// File: tb/isa_lane_adapter_test.sv
`timescale 1ns/1ps
module isa_lane_adapter_test;
    localparam int ADDR_W    = 4;
    localparam int WAIT_CLKS = 3;
    localparam int RST_IDX   = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_aen = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_ior_n = 1'b1;
    logic        bus_iow_n = 1'b1;
    logic        bus_sbhe_n = 1'b1;
    logic [15:0] bus_sd_in = '0;
    logic        cs16_sense = 1'b0;
    logic [7:0]  bus_sd_lo, bus_sd_hi;
    logic        bus_sd_lo_oe, bus_sd_hi_oe, bus_ready, bus_cs16_n;
    logic [2:0]  reg_idx;
    logic        reg_rd, reg_wr, soft_rst;
    logic [15:0] reg_wdata, reg_rdata;

    logic [15:0] model_regs [8];
    logic [15:0] exp_regs [8];
    int vecs = 0, fails = 0, wr_cnt = 0, srst_cnt = 0;
    bit exp_wide = 1'b0, mon_on = 1'b0;

    always #4 clk = ~clk;

    isa_lane_adapter #(.ADDR_W(ADDR_W), .WAIT_CLKS(WAIT_CLKS), .RST_IDX(RST_IDX)) uut (
        .clk(clk), .rst_n(rst_n), .bus_aen(bus_aen), .bus_addr(bus_addr),
        .bus_ior_n(bus_ior_n), .bus_iow_n(bus_iow_n), .bus_sbhe_n(bus_sbhe_n),
        .bus_sd_in(bus_sd_in), .cs16_sense(cs16_sense),
        .bus_sd_lo(bus_sd_lo), .bus_sd_hi(bus_sd_hi),
        .bus_sd_lo_oe(bus_sd_lo_oe), .bus_sd_hi_oe(bus_sd_hi_oe),
        .bus_ready(bus_ready), .bus_cs16_n(bus_cs16_n),
        .reg_idx(reg_idx), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .soft_rst(soft_rst)
    );

    // register bank model
    assign reg_rdata = model_regs[reg_idx];
    always @(posedge clk) begin
        if (reg_wr) begin
            model_regs[reg_idx] <= reg_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        if (soft_rst) srst_cnt <= srst_cnt + 1;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-clock comparison against the reference mode flag
    always @(negedge clk) begin
        if (mon_on) begin
            if (!exp_wide) chk("R11 cs16 idle in byte mode", {31'd0, bus_cs16_n}, 1);
            if (!exp_wide) chk("R4 hi lane off in byte mode", {31'd0, bus_sd_hi_oe}, 0);
        end
    end

    logic [7:0] s_lo, s_hi;
    bit s_lo_oe, s_hi_oe, s_cs_n;
    int s_lows;

    task automatic bus_cyc(input logic [3:0] a, input bit wr, input bit hb_n, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_sbhe_n = hb_n; bus_sd_in = d; bus_aen = 1'b0;
        if (wr) bus_iow_n = 1'b0; else bus_ior_n = 1'b0;
        s_lows = 0;
        do begin
            @(negedge clk);
            if (!bus_ready) s_lows++;
        end while (!bus_ready && s_lows < 50);
        s_lo = bus_sd_lo; s_hi = bus_sd_hi;
        s_lo_oe = bus_sd_lo_oe; s_hi_oe = bus_sd_hi_oe; s_cs_n = bus_cs16_n;
        chk("R3 ready low span", s_lows, WAIT_CLKS + 1);
        @(negedge clk);
        chk("R3 ready held until strobe release", {31'd0, bus_ready}, 1);
        bus_ior_n = 1'b1; bus_iow_n = 1'b1; bus_aen = 1'b1;
        @(negedge clk);
        chk("R13 drivers off after strobe", {30'd0, bus_sd_lo_oe, bus_sd_hi_oe}, 0);
    endtask

    int w0;

    initial begin
        for (int i = 0; i < 8; i++) begin
            model_regs[i] = 16'hA0B0 + 16'(i * 16'h0101);
            exp_regs[i]   = model_regs[i];
        end
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 ready", {31'd0, bus_ready}, 1);
        chk("R1 lane enables", {30'd0, bus_sd_lo_oe, bus_sd_hi_oe}, 0);
        chk("R1 cs16 out", {31'd0, bus_cs16_n}, 1);
        chk("R1 strobes", {29'd0, reg_rd, reg_wr, soft_rst}, 0);
        rst_n = 1'b1;
        mon_on = 1'b1;

        // R4 byte reads, even then odd
        bus_cyc(4'd2, 0, 1, 0);
        chk("R4 even byte", {24'd0, s_lo}, exp_regs[1][7:0]);
        chk("R4 lanes", {30'd0, s_lo_oe, s_hi_oe}, 2'b10);
        chk("R11 cs16 byte mode", {31'd0, s_cs_n}, 1);
        bus_cyc(4'd3, 0, 0, 0);
        chk("R4 odd byte swapped down", {24'd0, s_lo}, exp_regs[1][15:8]);
        chk("R4 hi lane off", {31'd0, s_hi_oe}, 0);

        // R6, R7 even-then-odd pair
        w0 = wr_cnt;
        bus_cyc(4'd4, 1, 1, 16'h005A);
        chk("R6 even write parked", wr_cnt - w0, 0);
        bus_cyc(4'd5, 1, 1, 16'h00C3);
        chk("R7 one merged write", wr_cnt - w0, 1);
        exp_regs[2] = 16'hC35A;
        bus_cyc(4'd4, 0, 1, 0);
        chk("R7 merged low byte", {24'd0, s_lo}, exp_regs[2][7:0]);
        bus_cyc(4'd5, 0, 1, 0);
        chk("R7 merged high byte", {24'd0, s_lo}, exp_regs[2][15:8]);

        // R8 lone odd, and pair broken by an intervening read
        w0 = wr_cnt;
        bus_cyc(4'd7, 1, 1, 16'h0011);
        chk("R8 lone odd ignored", wr_cnt - w0, 0);
        bus_cyc(4'd6, 1, 1, 16'h0022);
        bus_cyc(4'd2, 0, 1, 0);
        bus_cyc(4'd7, 1, 1, 16'h0033);
        chk("R8 broken pair ignored", wr_cnt - w0, 0);
        bus_cyc(4'd7, 0, 1, 0);
        chk("R8 word3 high unchanged", {24'd0, s_lo}, exp_regs[3][15:8]);

        // R2 enter word mode with a one-clock sense pulse
        @(negedge clk); cs16_sense = 1'b1; exp_wide = 1'b1;
        @(negedge clk); cs16_sense = 1'b0;
        repeat (3) @(negedge clk);
        bus_cyc(4'd2, 0, 0, 0);
        chk("R5 word read", {s_hi, s_lo}, exp_regs[1]);
        chk("R5 both lanes", {30'd0, s_lo_oe, s_hi_oe}, 2'b11);
        chk("R2 mode sticky / R11 cs16 low", {31'd0, s_cs_n}, 0);

        // R12 sbhe high forces byte cycle
        bus_cyc(4'd3, 0, 1, 0);
        chk("R12 byte cycle odd", {24'd0, s_lo}, exp_regs[1][15:8]);
        bus_cyc(4'd2, 0, 1, 0);
        chk("R12 hi lane off", {31'd0, s_hi_oe}, 0);

        // R9 word write bypasses holding register
        w0 = wr_cnt;
        bus_cyc(4'd8, 1, 0, 16'h1234);
        chk("R9 one word write", wr_cnt - w0, 1);
        exp_regs[4] = 16'h1234;
        bus_cyc(4'd8, 0, 0, 0);
        chk("R9 word readback", {s_hi, s_lo}, exp_regs[4]);

        // R10 reset-address write: no effect
        w0 = wr_cnt;
        bus_cyc(4'd14, 1, 0, 16'hFFFF);
        chk("R10 write no soft reset", srst_cnt, 0);
        chk("R10 write no reg write", wr_cnt - w0, 0);

        // R10 reset-address read
        bus_cyc(4'd14, 0, 0, 0);
        exp_wide = 1'b0;
        chk("R10 soft reset pulse", srst_cnt, 1);
        chk("R10 read data", {24'd0, s_lo}, 0);
        chk("R11 no cs16 on reset address", {31'd0, s_cs_n}, 1);
        bus_cyc(4'd2, 0, 0, 0);
        chk("R2 mode cleared by soft reset", {31'd0, s_hi_oe}, 0);
        chk("R4 byte after soft reset", {24'd0, s_lo}, exp_regs[1][7:0]);

        mon_on = 1'b0;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

    initial begin
        #(8 * 100000);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end
endmodule